// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is an SPI slave that lets an external host read and write an internal register space. The host pulls the active-low chip select low, clocks in a 16-bit command header on the data-in line, then moves one data byte. A write shifts the byte in after the header. A read shifts the addressed register's byte out on the data-out line. The chip select is then released.

All pin inputs are brought into the system clock domain by a synchroniser, and SCLK edges are detected there. SCLK idles low between transfers, and its rate must be no more than one quarter of the system clock rate.

The core side is a plain register bus with an address, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data input. The data-out pin is delivered as a value plus an output enable, and the pad cell combines the two into a tri-state driver.

Top module: `spi_regport_top`

## Requirements
- R1: After reset, and whenever chip select is high, the output enable is low and neither core strobe is issued.
- R2: Header bits are sampled on rising SCLK, most significant bit first. Header bit 15 is the operation flag: 1 means read and 0 means write. Header bits 14 to 11 are ignored. Header bits 10 to 0 are the register address, most significant bit first.
- R3: For a write, the eight bits after the header are sampled on rising SCLK, most significant bit first. Exactly one write strobe is issued, carrying the address and data, once the 24th bit has been captured.
- R4: For a read, exactly one read strobe is issued, carrying the address, once the 16th bit has been captured. The read-data input is taken in the cycle the strobe is high.
- R5: For a read, the register byte appears on the data-out pin most significant bit first. Each bit changes only after a falling SCLK edge, and the first bit follows the falling edge after the 16th rising edge. The value is stable while SCLK is high.
- R6: The output enable stays low while the header is being shifted in. It is low within four system clocks after chip select rises, and it is only ever high during a read.
- R7: If chip select rises before the 24th bit of a write, no write strobe is issued. The next chip select assertion starts header reception again from bit 15.
- R8: SCLK edges after the 24th bit have no effect: no further strobe is issued and the stored write data is unchanged.
- R9: A read transfer issues no write strobe, a write transfer issues no read strobe, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| reg_addr | output | ADDR_W (11) | Register address for both strobes |
| reg_wdata | output | DATA_W (8) | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W (8) | Read data, valid while reg_rd is high |

## Verification
The bench builds the block with its default parameters: an 11-bit address, 8-bit data and a two-stage synchroniser. The wide address lets the frame vectors reach address 0, address 0x7FF and the top-bit boundary 0x400. Nonzero ignored header bits are mixed in to show that they have no effect. The bench drives SCLK at one twelfth of the system clock, so the two-stage synchroniser delay sits well inside each SCLK half-period. With that margin, the data-out value can be checked during both the low and the high SCLK phase.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    // Geometry of one transfer
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int HDR_W  = 16;
    localparam int CNT_W  = $clog2(HDR_W + 1);

    // Transfer phase within one chip-select window
    typedef enum logic [1:0] {
        PH_HDR   = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // Address carried in the low header bits; last bit arrives directly
    function automatic logic [ADDR_W-1:0] hdr_addr(input logic [HDR_W-2:0] held,
                                                   input logic last_bit);
        return {held[ADDR_W-2:0], last_bit};
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg_q <= RST_VAL;
                else     stg_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg_q <= {STAGES{RST_VAL}};
                else     stg_q <= {stg_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sdo_bit,
    output logic              sdo_oe
);
    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-2:0]  shift_q;
    logic [DATA_W-1:0] dout_q;
    logic              sclk_prev_q;
    logic              is_read_q;
    logic              sclk_rise, sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s & sclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else if (cs_act && sclk_rise) begin
            if (phase_q == PH_HDR && cnt_q == CNT_W'(HDR_W - 1))
                reg_addr <= hdr_addr(shift_q, sdi_s);
            if (phase_q == PH_WDATA && cnt_q == CNT_W'(DATA_W - 1))
                reg_wdata <= {shift_q[DATA_W-2:0], sdi_s};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            phase_q   <= PH_HDR;
            cnt_q     <= '0;
            shift_q   <= '0;
            dout_q    <= '0;
            is_read_q <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            sdo_bit   <= 1'b0;
            sdo_oe    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_rd) dout_q <= reg_rdata;
            if (sclk_rise) begin
                case (phase_q)
                    PH_HDR: begin
                        shift_q <= {shift_q[HDR_W-3:0], sdi_s};
                        if (cnt_q == CNT_W'(HDR_W - 1)) begin
                            cnt_q     <= '0;
                            is_read_q <= shift_q[HDR_W-2];
                            if (shift_q[HDR_W-2]) begin
                                phase_q <= PH_RDATA;
                                reg_rd  <= 1'b1;
                            end else begin
                                phase_q <= PH_WDATA;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_WDATA: begin
                        shift_q <= {shift_q[HDR_W-3:0], sdi_s};
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            reg_wr  <= 1'b1;
                            phase_q <= PH_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_RDATA: begin
                        if (cnt_q == CNT_W'(DATA_W - 1)) phase_q <= PH_DONE;
                        else                             cnt_q   <= cnt_q + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (sclk_fall && phase_q == PH_RDATA) begin
                sdo_oe  <= 1'b1;
                sdo_bit <= dout_q[DATA_W-1];
                dout_q  <= {dout_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Checks next to the logic they guard
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);
    assert_wr_full_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (phase_q == PH_DONE && !is_read_q));
    assert_rd_single_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);
    assert_rd_phase_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> (phase_q == PH_RDATA && cnt_q == '0));
    assert_oe_read_R6: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (is_read_q && phase_q != PH_HDR));
    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!reg_wr && !reg_rd && !sdo_oe));
    assert_sdo_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !sclk_fall && cs_act) |=> $stable(sdo_bit));
endmodule

// File: rtl/spi_regport_top.sv
module spi_regport_top
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;

    logic [PIN_N-1:0] pins_s;

    spi_regport_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_in({spi_csn, spi_sclk, spi_mosi}),
        .sync_out(pins_s)
    );

    spi_regport_engine engine_i (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (~pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata),
        .sdo_bit  (spi_miso),
        .sdo_oe   (spi_miso_oe)
    );
endmodule

// File: tb/spi_regport_top_tb_top.sv
module spi_regport_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;
    logic [10:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [10:0] last_wa, last_ra;
    logic [7:0]  last_wd;
    logic [7:0]  mem [0:2047];
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_regport_top dut_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt++;
            last_wa <= reg_addr;
            last_wd <= reg_wdata;
            mem[reg_addr] <= reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt++;
            last_ra <= reg_addr;
        end
    end

    // Frame = {op, ignored[3:0], addr[10:0], data[7:0]}; for reads data is the expected value
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 4'h0, 11'h000, 8'hA5},
        {1'b0, 4'h0, 11'h7FF, 8'h3C},
        {1'b0, 4'hF, 11'h400, 8'h81},
        {1'b0, 4'hA, 11'h155, 8'h5A},
        {1'b1, 4'h5, 11'h000, 8'hA5},
        {1'b1, 4'h0, 11'h7FF, 8'h3C},
        {1'b1, 4'hF, 11'h400, 8'h81},
        {1'b1, 4'h0, 11'h155, 8'h5A}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sends nbits from frame[31] downward; returns read byte and phase violations
    task automatic xfer(input logic [31:0] frame, input int nbits,
                        output logic [7:0] rbits, output int hdr_oe, output int unstable);
        logic lowv;
        rbits = '0; hdr_oe = 0; unstable = 0; lowv = 1'b0;
        @(negedge clk); csn = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); mosi = frame[31-i];
            repeat (5) @(negedge clk);
            if (i < 16 && miso_oe !== 1'b0) hdr_oe++;
            if (i >= 16 && i < 24) begin
                lowv = miso;
                rbits[23-i] = miso;
                if (miso_oe !== 1'b1) unstable++;
            end
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            if (i >= 16 && i < 24 && miso !== lowv) unstable++;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        csn = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        int hv, uv, w0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(miso_oe === 1'b0, "R1", "oe after reset", miso_oe, 0);
        check(reg_wr === 1'b0 && reg_rd === 1'b0, "R1", "strobes after reset", {reg_wr, reg_rd}, 0);

        for (int v = 0; v < NVEC; v++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            xfer({VEC[v], 8'h00}, 24, rb, hv, uv);
            repeat (4) @(negedge clk);
            check(miso_oe === 1'b0, "R6", "oe after cs high", miso_oe, 0);
            check(hv == 0, "R6", "oe during header", hv, 0);
            if (!VEC[v][23]) begin
                check(wr_cnt - w0 == 1, "R3", "write strobe count", wr_cnt - w0, 1);
                check(rd_cnt == r0, "R9", "read strobe on write", rd_cnt - r0, 0);
                check(last_wa == VEC[v][18:8], "R2", "write address", last_wa, VEC[v][18:8]);
                check(last_wd == VEC[v][7:0], "R3", "write data", last_wd, VEC[v][7:0]);
            end else begin
                check(rd_cnt - r0 == 1, "R4", "read strobe count", rd_cnt - r0, 1);
                check(wr_cnt == w0, "R9", "write strobe on read", wr_cnt - w0, 0);
                check(last_ra == VEC[v][18:8], "R2", "read address", last_ra, VEC[v][18:8]);
                check(rb == VEC[v][7:0], "R5", "read data on sdo", rb, VEC[v][7:0]);
                check(uv == 0, "R5", "sdo phase/stability", uv, 0);
            end
        end

        // R7: write aborted after 20 bits
        w0 = wr_cnt;
        xfer({1'b0, 4'h0, 11'h155, 8'hEE, 8'h00}, 20, rb, hv, uv);
        repeat (4) @(negedge clk);
        check(wr_cnt == w0, "R7", "aborted write strobe", wr_cnt - w0, 0);
        // R7: header aborted after 10 bits, next frame restarts at bit 15
        xfer({1'b0, 4'h0, 11'h6C3, 8'h11, 8'h00}, 10, rb, hv, uv);
        xfer({1'b0, 4'h0, 11'h123, 8'h77, 8'h00}, 24, rb, hv, uv);
        repeat (4) @(negedge clk);
        check(last_wa == 11'h123 && last_wd == 8'h77, "R7", "restart after abort",
              {last_wa, last_wd}, {11'h123, 8'h77});
        xfer({1'b1, 4'h0, 11'h155, 8'h00, 8'h00}, 24, rb, hv, uv);
        check(rb == 8'h5A, "R7", "aborted write left data", rb, 8'h5A);

        // R8: extra bits after a write
        w0 = wr_cnt;
        xfer({1'b0, 4'h0, 11'h0AA, 8'hC3, 8'hFF}, 32, rb, hv, uv);
        repeat (4) @(negedge clk);
        check(wr_cnt - w0 == 1, "R8", "strobes with extra bits", wr_cnt - w0, 1);
        check(last_wd == 8'hC3, "R8", "data with extra bits", last_wd, 8'hC3);
        r0 = rd_cnt;
        xfer({1'b1, 4'h0, 11'h0AA, 8'h00, 8'hFF}, 32, rb, hv, uv);
        check(rd_cnt - r0 == 1, "R8", "read strobes with extra bits", rd_cnt - r0, 1);
        check(rb == 8'hC3, "R8", "read back after extra bits", rb, 8'hC3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule